// File: doc/BRIEF.md
# Timer Event Flags with Read-Then-Write Clearing

This block holds the pending-event flags of a timer: one flag for counter overflow and one for each capture/compare channel. A one-cycle event pulse from the timer logic sets the matching flag. Each flag has its own enable, and the interrupt request for that source is a level that stays high while both the flag and its enable are 1.

Software clears a flag in two steps. First it reads the flag register while the flag is 1, which arms that flag. Then it writes 0 to that bit. If a new event reaches an armed flag before the write, the arming is dropped and the flag stays set, so that the new event is not lost. Any write to the register disarms every flag. A write of 1 to a bit never changes that bit. Bit 0 is the overflow flag. Bit k, for k from 1 to the channel count, is the flag of channel k-1.

Top module: `tflag_bank`

## Requirements
- R1: After reset every flag and every interrupt request is 0.
- R2: An event pulse on bit i sets flag i on the next clock edge. Flag i then stays 1 until it is cleared.
- R3: Interrupt request i is high exactly while flag i and enable i are both 1. It is combinational in the enable, and the enable does not change the flag.
- R4: A read while flag i is 1, followed by a write whose data bit i is 0, clears flag i on the edge that ends the write cycle.
- R5: A write of 0 to bit i with no arming read before it leaves flag i at 1.
- R6: A write with data bit i equal to 1 leaves flag i unchanged, whether or not flag i is armed. Other bits in the same write are handled on their own.
- R7: An event on bit i between the arming read and the clearing write disarms flag i, so the write leaves it at 1.
- R8: When an event on bit i arrives in the same cycle as a valid clearing write to bit i, flag i stays 1.
- R9: Arming applies to each flag on its own. A read arms only the flags that are 1 in that read cycle.
- R10: Every write disarms all flags. After a write that does not clear a bit, a later write of 0 to that bit needs a fresh read.
- R11: A read in the same cycle as an event on bit i does not arm flag i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | N_CH+1 | Event pulses, bit 0 overflow, bit k channel k-1 |
| rd_i | input | 1 | Read strobe of the flag register |
| wr_i | input | 1 | Write strobe of the flag register |
| wdata_i | input | N_CH+1 | Write data, 0 requests a clear of that bit |
| en_i | input | N_CH+1 | Interrupt enables, one per flag |
| flag_o | output | N_CH+1 | Current flag values, also the read data |
| irq_o | output | N_CH+1 | Level interrupt requests |

## Verification
The bench puts events in each position of the clearing handshake: between the read and the write, in the same cycle as the write, and in the same cycle as the read. A design that kept the arming through an event would lose that event and show a 0 flag where the model still holds a 1. Writes with no read before them, writes of 1, and a write of 0 after a write that did not clear are also sent. A design that cleared without arming, or did not disarm on every write, would drop flags that must stay set. A per-flag case, where one flag is armed and another is set after the read, catches a design that shares one arming bit between the flags. That design would clear the wrong bit or fail to clear the right one.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
    typedef struct packed {
        logic flag;
        logic arm;
    } cell_state_t;

    localparam cell_state_t CELL_RESET = '{flag: 1'b0, arm: 1'b0};
endpackage

// File: rtl/tflag_cell.sv
module tflag_cell
    import tflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    cell_state_t st_d, st_q;
    logic        clear_ok;

    always_comb begin
        st_d     = st_q;
        clear_ok = wr_i & ~wbit_i & st_q.arm;
        // Any write ends the handshake. A read arms only a set flag.
        if (wr_i) begin
            st_d.arm = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        // A new event always wins and drops the arming.
        if (evt_i) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end else if (clear_ok) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CELL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/tflag_gate.sv
module tflag_gate #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] flag_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] irq_o
);
    always_comb begin
        irq_o = flag_i & en_i;
    end
endmodule

// File: rtl/tflag_bank.sv
module tflag_bank #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH:0]   evt_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [N_CH:0]   wdata_i,
    input  logic [N_CH:0]   en_i,
    output logic [N_CH:0]   flag_o,
    output logic [N_CH:0]   irq_o
);
    localparam int N_FLAG = N_CH + 1;

    logic [N_FLAG-1:0] flag_w;

    for (genvar gi = 0; gi < N_FLAG; gi++) begin : g_cell
        tflag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[gi]),
            .rd_i   (rd_i),
            .wr_i   (wr_i),
            .wbit_i (wdata_i[gi]),
            .flag_o (flag_w[gi])
        );
    end

    tflag_gate #(.WIDTH(N_FLAG)) u_gate (
        .flag_i (flag_w),
        .en_i   (en_i),
        .irq_o  (irq_o)
    );

    assign flag_o = flag_w;
endmodule

// File: rtl/tflag_bank_chk.sv
module tflag_bank_chk #(
    parameter int N_CH = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N_CH:0] evt_i,
    input logic          wr_i,
    input logic [N_CH:0] wdata_i,
    input logic [N_CH:0] en_i,
    input logic [N_CH:0] flag_o,
    input logic [N_CH:0] irq_o
);
    localparam int N_FLAG = N_CH + 1;

    for (genvar gi = 0; gi < N_FLAG; gi++) begin : g_chk
        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[gi] |=> flag_o[gi]);

        a_r3_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[gi] == (flag_o[gi] & en_i[gi]));

        a_r4_fall_only_on_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_o[gi]) |-> $past(wr_i && !wdata_i[gi] && !evt_i[gi]));

        a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[gi] && wr_i && wdata_i[gi]) |=> flag_o[gi]);

        a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[gi] && !wr_i) |=> flag_o[gi]);
    end
endmodule

bind tflag_bank tflag_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .en_i    (en_i),
    .flag_o  (flag_o),
    .irq_o   (irq_o)
);

// File: tb/tflag_bank_bench.sv
module tflag_bank_bench;
    localparam int N_CH = 2;
    localparam int NF   = N_CH + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] evt = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [NF-1:0] wd = '0;
    logic [NF-1:0] en = '0;
    logic [NF-1:0] flag;
    logic [NF-1:0] irq;

    int total = 0;
    int bad   = 0;

    // behavioural reference
    bit m_flag [NF];
    bit m_arm  [NF];

    always #10 clk = ~clk;

    tflag_bank #(.N_CH(N_CH)) u_tflag_bank (
        .clk (clk), .rst_n (rst_n), .evt_i (evt), .rd_i (rd), .wr_i (wr),
        .wdata_i (wd), .en_i (en), .flag_o (flag), .irq_o (irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) begin
                m_flag[i] <= 1'b0;
                m_arm[i]  <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (evt[i]) begin
                    m_flag[i] <= 1'b1;
                    m_arm[i]  <= 1'b0;
                end else begin
                    if (wr && !wd[i] && m_arm[i]) m_flag[i] <= 1'b0;
                    if (wr) m_arm[i] <= 1'b0;
                    else if (rd && m_flag[i]) m_arm[i] <= 1'b1;
                end
            end
        end
    end

    function automatic logic [NF-1:0] model_vec();
        logic [NF-1:0] v;
        for (int i = 0; i < NF; i++) v[i] = m_flag[i];
        return v;
    endfunction

    task automatic chk(input string req, input logic [NF-1:0] act, input logic [NF-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2/R4 model flags", flag, model_vec());
            chk("R3 model irq", irq, model_vec() & en);
        end
    end

    task automatic step(input logic [NF-1:0] e, input logic r, input logic w, input logic [NF-1:0] d);
        evt = e; rd = r; wr = w; wd = d;
        @(posedge clk);
        @(negedge clk);
        evt = '0; rd = 1'b0; wr = 1'b0; wd = '0;
        #1;
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flags", flag, '0);
        chk("R1 reset irq", irq, '0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        en = '1; #1;

        step(3'b001, 0, 0, '0);
        chk("R2 event sets", flag, 3'b001);
        chk("R3 irq on", irq, 3'b001);
        en = '0; #1;
        chk("R3 irq off by enable", irq, 3'b000);
        chk("R3 enable leaves flag", flag, 3'b001);
        en = '1; #1;

        step('0, 0, 1, 3'b000);
        chk("R5 write zero without read", flag, 3'b001);

        step('0, 1, 0, '0);
        step('0, 0, 1, 3'b000);
        chk("R4 read then write zero", flag, 3'b000);

        step(3'b001, 0, 0, '0);
        step('0, 1, 0, '0);
        step('0, 0, 1, 3'b111);
        chk("R6 write one keeps", flag, 3'b001);
        step('0, 0, 1, 3'b000);
        chk("R10 write disarms", flag, 3'b001);

        step('0, 1, 0, '0);
        step(3'b001, 0, 0, '0);
        step('0, 0, 1, 3'b000);
        chk("R7 event mid sequence", flag, 3'b001);

        step('0, 1, 0, '0);
        step(3'b001, 0, 1, 3'b000);
        chk("R8 event with write", flag, 3'b001);

        step('0, 1, 0, '0);
        step(3'b010, 0, 0, '0);
        step('0, 0, 1, 3'b000);
        chk("R9 per flag arming", flag, 3'b010);

        step(3'b010, 1, 0, '0);
        step('0, 0, 1, 3'b000);
        chk("R11 read with event", flag, 3'b010);
        step('0, 1, 0, '0);
        step('0, 0, 1, 3'b000);
        chk("R4 later clear", flag, 3'b000);

        step(3'b111, 0, 0, '0);
        step('0, 1, 0, '0);
        step('0, 0, 1, 3'b101);
        chk("R6 selective clear", flag, 3'b101);
        chk("R3 irq follows", irq, 3'b101);
        step('0, 1, 0, '0);
        step('0, 0, 1, 3'b000);
        chk("R4 clear all", flag, 3'b000);

        for (int k = 0; k < 40; k++) begin
            step(NF'((k * 5) % 8) & NF'(k % 3 == 0 ? 7 : 0), (k % 2) == 1, (k % 4) == 2, NF'(k % 8));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule